// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits beside the register file of a serial port and decides which interrupt the host sees. It takes four interrupt conditions, gates each with an enable mask, and ranks them by a fixed priority. The result is one interrupt line and an eight-bit identification value that the host reads. The block also owns the clear-on-read side effects that belong to interrupts. These are: the read of the identification value, the read of the line status, the read of the modem status, the read of receive data, and the write of transmit data. It keeps the four modem change flags and returns the modem status byte. A master gate bit from the modem control register must be set before the interrupt line can assert.

The identification value is a registered snapshot. While the host holds the identification read strobe, the snapshot stays frozen. Events that arrive during the read are still latched, and they appear in the snapshot once the strobe drops. The data paths and the FIFOs are not part of this block. It sees only their condition flags: data available, timeout pulse, error pulse and holding empty.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification value is 8'h01, the modem change flags are 0 and `irq` is low. Bit 0 of the identification value is 0 when an enabled interrupt is pending and 1 when none is pending.
- R2: Bits 3:1 give the highest-priority enabled condition, in this order: line error 3'b011, timeout 3'b110, receive data 3'b010, transmit empty 3'b001, modem change 3'b000. When nothing is pending the code is 3'b000.
- R3: In non-FIFO mode bit 3 of the identification value is 0 and no timeout is held. Bits 7:6 read 2'b11 exactly when `fifo_mode` is 1. Bit 5 reads `fifo_mode & fifo_big`. Bit 4 is 0.
- R4: While `ident_rd` is high the identification value does not change. Otherwise it takes, one cycle later, the value the current pending state implies.
- R5: The transmit-empty condition sets on a rising edge of `tx_empty`. It also sets when `fifo_mode` rises while `tx_empty` is 1. It clears on `tx_wr`, or on the first cycle of an identification read whose snapshot shows 4'b0010. A set in the same cycle takes precedence over a clear.
- R6: A `line_err` pulse latches the line condition until `line_rd`. A `rx_timeout` pulse in FIFO mode latches the timeout until `data_rd`. Receive data follows the `rx_ready` level.
- R7: Modem status bits 3..0 are the change flags for DCD, trailing-edge RI, DSR and CTS. They set on any level change of `dcd_n`, `dsr_n` or `cts_n`, and on a low-to-high change of `ri_n`. They clear on `modem_rd`, except for a flag whose event occurs in that same cycle.
- R8: Modem status bits 7..4 are the complements of `dcd_n`, `ri_n`, `dsr_n` and `cts_n`.
- R9: `irq` equals `out2` AND any enabled pending condition. Enable bit 0 gates receive data and timeout, bit 1 gates transmit empty, bit 2 gates the line condition and bit 3 gates the modem change flags. A masked condition appears in neither `irq` nor the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 4 | Enable mask: [0] receive/timeout, [1] transmit empty, [2] line error, [3] modem |
| fifo_mode | input | 1 | FIFO mode is on |
| fifo_big | input | 1 | Large FIFO mode is selected |
| out2 | input | 1 | Master interrupt gate |
| rx_ready | input | 1 | Receive data available (level) |
| rx_timeout | input | 1 | Receive timeout event (pulse) |
| line_err | input | 1 | Line error or break event (pulse) |
| tx_empty | input | 1 | Transmit holding empty (level) |
| ident_rd | input | 1 | Identification read strobe, held for the whole access |
| line_rd | input | 1 | Line status read strobe |
| modem_rd | input | 1 | Modem status read strobe |
| data_rd | input | 1 | Receive data read strobe |
| tx_wr | input | 1 | Transmit data write strobe |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| irq | output | 1 | Interrupt request |
| ident | output | 8 | Identification value |
| modem_stat | output | 8 | Modem status byte |

## Verification
Directed sequences stack several conditions at once and then remove them one by one through their clearing strobes. This shows the priority order and confirms that each strobe clears only its own condition. Identification reads that span events check that the snapshot stays frozen and that the transmit-empty clear applies only to a snapshot that showed it. RI pulses in both directions separate the trailing-edge rule from the any-edge rule used by the other pins. Long random runs with sticky read strobes and random masks check the same rules across collisions between a set and a clear in one cycle.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_en,
  input  logic       fifo_mode,
  input  logic       fifo_big,
  input  logic       out2,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       line_err,
  input  logic       tx_empty,
  input  logic       ident_rd,
  input  logic       line_rd,
  input  logic       modem_rd,
  input  logic       data_rd,
  input  logic       tx_wr,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       irq,
  output logic [7:0] ident,
  output logic [7:0] modem_stat
);

  logic [3:0] pin_q, delta;
  logic       ls_pend, to_pend, tx_pend;
  logic       thre_q, fifo_q, rd_q;
  logic [2:0] code;
  logic       pend;

  wire [3:0] pins = {dcd_n, ri_n, dsr_n, cts_n};
  wire [3:0] chg  = {pins[3] ^ pin_q[3], pins[2] & ~pin_q[2],
                     pins[1] ^ pin_q[1], pins[0] ^ pin_q[0]};
  wire tx_set = (tx_empty & ~thre_q) | (fifo_mode & ~fifo_q & tx_empty);
  wire tx_clr = tx_wr | (ident_rd & ~rd_q & (ident[3:0] == 4'b0010));

  always_comb begin
    pend = 1'b1;
    code = 3'b000;
    if (irq_en[2] && ls_pend)                     code = 3'b011;
    else if (irq_en[0] && fifo_mode && to_pend)   code = 3'b110;
    else if (irq_en[0] && rx_ready)               code = 3'b010;
    else if (irq_en[1] && tx_pend)                code = 3'b001;
    else if (irq_en[3] && (|delta))               code = 3'b000;
    else                                          pend = 1'b0;
  end

  wire [7:0] live = {{2{fifo_mode}}, fifo_mode & fifo_big, 1'b0, code, ~pend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= 4'hF;
      delta   <= 4'h0;
      ls_pend <= 1'b0;
      to_pend <= 1'b0;
      tx_pend <= 1'b0;
      thre_q  <= 1'b1;
      fifo_q  <= 1'b0;
      rd_q    <= 1'b0;
      ident   <= 8'h01;
    end else begin
      pin_q   <= pins;
      delta   <= chg | (modem_rd ? 4'h0 : delta);
      ls_pend <= line_err | (ls_pend & ~line_rd);
      to_pend <= fifo_mode & (rx_timeout | (to_pend & ~data_rd));
      tx_pend <= tx_set | (tx_pend & ~tx_clr);
      thre_q  <= tx_empty;
      fifo_q  <= fifo_mode;
      rd_q    <= ident_rd;
      if (!ident_rd) ident <= live;
    end
  end

  assign irq        = out2 & pend;
  assign modem_stat = {~pins, delta};

  AST_IDENT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ident_rd |=> $stable(ident)); // R4
  AST_NO_TIMEOUT_OUTSIDE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !to_pend); // R3
  AST_LINE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> ls_pend); // R6
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_set) |=> !tx_pend); // R5
  AST_MODEM_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_rd && chg == 4'h0) |=> (modem_stat[3:0] == 4'h0)); // R7
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ls_pend || rx_ready || to_pend || tx_pend || (|delta))); // R9

endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic clk = 0, rst_n = 0;
  logic [3:0] irq_en = 0;
  logic fifo_mode = 0, fifo_big = 0, out2 = 0;
  logic rx_ready = 0, rx_timeout = 0, line_err = 0, tx_empty = 0;
  logic ident_rd = 0, line_rd = 0, modem_rd = 0, data_rd = 0, tx_wr = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic irq;
  logic [7:0] ident, modem_stat;

  int tests = 0, fails = 0;

  logic m_ls = 0, m_to = 0, m_tx = 0;
  logic [3:0] m_d = 0, p_pins = 4'hF;
  logic p_thre = 1, p_fifo = 0, p_rd = 0;
  logic [7:0] m_ident = 8'h01;

  always #4 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  function automatic logic [7:0] live_fn(logic ls, logic to, logic tx, logic [3:0] d);
    logic [2:0] c = 3'b000;
    logic p = 1'b1;
    if (irq_en[2] && ls) c = 3'b011;
    else if (irq_en[0] && fifo_mode && to) c = 3'b110;
    else if (irq_en[0] && rx_ready) c = 3'b010;
    else if (irq_en[1] && tx) c = 3'b001;
    else if (irq_en[3] && (|d)) c = 3'b000;
    else p = 1'b0;
    return {{2{fifo_mode}}, fifo_mode & fifo_big, 1'b0, c, ~p};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    logic [7:0] lv, lv2;
    logic [3:0] pins, chg;
    logic txs, txc;
    lv   = live_fn(m_ls, m_to, m_tx, m_d);
    pins = {dcd_n, ri_n, dsr_n, cts_n};
    chg  = {pins[3] ^ p_pins[3], pins[2] & ~p_pins[2], pins[1] ^ p_pins[1], pins[0] ^ p_pins[0]};
    txs  = (tx_empty & ~p_thre) | (fifo_mode & ~p_fifo & tx_empty);
    txc  = tx_wr | (ident_rd & ~p_rd & (m_ident[3:0] == 4'b0010));
    m_d  = chg | (modem_rd ? 4'h0 : m_d);
    m_ls = line_err | (m_ls & ~line_rd);
    m_to = fifo_mode & (rx_timeout | (m_to & ~data_rd));
    m_tx = txs | (m_tx & ~txc);
    if (!ident_rd) m_ident = lv;
    p_pins = pins; p_thre = tx_empty; p_fifo = fifo_mode; p_rd = ident_rd;
    @(negedge clk);
    lv2 = live_fn(m_ls, m_to, m_tx, m_d);
    chk("R2", ident, m_ident);
    chk("R7", {4'h0, modem_stat[3:0]}, {4'h0, m_d});
    chk("R8", {4'h0, modem_stat[7:4]}, {4'h0, ~{dcd_n, ri_n, dsr_n, cts_n}});
    chk("R9", {7'h0, irq}, {7'h0, out2 & ~lv2[0]});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", ident, 8'h01);
    chk("R1", modem_stat, 8'h00);
    chk("R1", {7'h0, irq}, 8'h00);
    irq_en = 4'hF; out2 = 1;

    line_err = 1; step(); line_err = 0; step();
    chk("R2", ident, 8'h06);
    rx_ready = 1; line_rd = 1; step(); line_rd = 0; step();
    chk("R6", ident, 8'h04);
    rx_ready = 0; step(); step();
    chk("R1", ident, 8'h01);

    fifo_mode = 1; fifo_big = 1; step();
    rx_timeout = 1; step(); rx_timeout = 0; step();
    chk("R3", ident, 8'hEC);
    data_rd = 1; step(); data_rd = 0; step();
    chk("R6", ident, 8'hE1);
    rx_timeout = 1; step(); rx_timeout = 0; fifo_mode = 0; step(); step();
    chk("R3", ident, 8'h01);
    fifo_big = 0;

    tx_empty = 1; step(); step();
    chk("R5", ident, 8'h02);
    ident_rd = 1; step(); line_err = 1; step(); line_err = 0; step();
    chk("R4", ident, 8'h02);
    ident_rd = 0; step();
    chk("R4", ident, 8'h06);
    line_rd = 1; step(); line_rd = 0; step();
    chk("R5", ident, 8'h01);

    tx_empty = 0; step(); tx_empty = 1; step(); step();
    chk("R5", ident, 8'h02);
    tx_wr = 1; step(); tx_wr = 0; step();
    chk("R5", ident, 8'h01);
    fifo_mode = 1; step(); step();
    chk("R5", ident, 8'hC2);
    tx_wr = 1; step(); tx_wr = 0; fifo_mode = 0; step(); step();

    ri_n = 0; step(); step();
    chk("R7", modem_stat, 8'h40);
    ri_n = 1; step();
    chk("R7", modem_stat, 8'h04);
    step();
    chk("R2", ident, 8'h00);
    out2 = 0; step();
    chk("R9", {7'h0, irq}, 8'h00);
    out2 = 1;
    cts_n = 0; modem_rd = 1; step();
    chk("R7", modem_stat, 8'h11);
    modem_rd = 0; cts_n = 1; step();
    chk("R7", modem_stat, 8'h01);
    modem_rd = 1; step(); modem_rd = 0; step();
    chk("R7", modem_stat, 8'h00);
    irq_en = 4'h0; tx_empty = 0; step(); tx_empty = 1; step(); step();
    chk("R9", {7'h0, irq}, 8'h00);
    chk("R9", ident, 8'h01);

    for (int n = 0; n < 4000; n++) begin
      irq_en     = ($urandom_range(0, 7) == 0) ? 4'($urandom) : irq_en;
      if ($urandom_range(0, 30) == 0) fifo_mode = ~fifo_mode;
      fifo_big   = 1'($urandom);
      out2       = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 5) == 0) rx_ready = ~rx_ready;
      rx_timeout = ($urandom_range(0, 12) == 0);
      line_err   = ($urandom_range(0, 12) == 0);
      if ($urandom_range(0, 6) == 0) tx_empty = ~tx_empty;
      if ($urandom_range(0, 3) == 0) ident_rd = ~ident_rd;
      line_rd    = ($urandom_range(0, 8) == 0);
      modem_rd   = ($urandom_range(0, 8) == 0);
      data_rd    = ($urandom_range(0, 8) == 0);
      tx_wr      = ($urandom_range(0, 10) == 0);
      if ($urandom_range(0, 9) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 9) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(0, 9) == 0) ri_n  = ~ri_n;
      if ($urandom_range(0, 9) == 0) dcd_n = ~dcd_n;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule